// File: doc/BRIEF.md
# Operand Bypass Selector for a Four-Stage Pipeline

This block decides, for every source operand of the instruction now executing, whether the register file copy of that operand is still current. In a fetch / decode / execute / writeback pipeline, a result reaches the register file two cycles after its instruction left decode. The two instructions that follow a writer therefore read a stale copy of its destination. The selector compares each source index with the destinations of the two older instructions that are still ahead. When it finds a match, it routes the newer value to the operand in place of the register file value.

The block is purely combinational. Instruction decode and the pipeline registers belong to the surrounding core. The core supplies the source indices, the register file read data, and for each of the two older slots a write enable, a destination index and the candidate result. In this text, "slot 1" is the older instruction directly ahead of the executing one, and "slot 2" is the instruction ahead of that. For every operand the block returns a 2-bit select code and the resolved data.

Top module: `raw_fwd_unit`

## Requirements
- R1: When no enabled older slot targets an operand's source index, that operand's select is 2'b00 and its data equals its register file input.
- R2: When slot 1 has its write enable high and its destination equals the source index, the select is 2'b01 and the data equals the slot 1 result.
- R3: When only slot 2 (write enable high) targets the source index, the select is 2'b10 and the data equals the slot 2 result.
- R4: When both slots are enabled and target the same register the operand reads, slot 1 (the younger of the two) wins, so the select is 2'b01.
- R5: A slot whose write enable is low never feeds an operand, even when its destination index matches.
- R6: Each operand is resolved on its own, so two operands in the same cycle can receive different select codes.
- R7: The select code 2'b11 never appears on any operand.
- R8: Outputs follow input changes within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_idx | input | NUM_SRC x REG_W | Source register index of each operand |
| rf_data | input | NUM_SRC x DATA_W | Register file read data for each operand |
| age1_we | input | 1 | Slot 1 writes a register |
| age1_dst | input | REG_W | Slot 1 destination index |
| age1_val | input | DATA_W | Slot 1 result |
| age2_we | input | 1 | Slot 2 writes a register |
| age2_dst | input | REG_W | Slot 2 destination index |
| age2_val | input | DATA_W | Slot 2 result |
| fwd_sel | output | NUM_SRC x 2 | Per-operand select: 00 register file, 01 slot 1, 10 slot 2 |
| opnd_data | output | NUM_SRC x DATA_W | Resolved operand value |

## Verification
The hardest situation to reach from the ports is a pair of operands that read the same register while both slots target it, with one slot's write enable dropped. In that case priority and enable gating interact. The stimulus builds this case step by step. First both slots are enabled and aimed at one index. Then slot 1's enable is cleared while its destination still matches, and the bench confirms that the operand falls back to slot 2. Then slot 2's enable is cleared as well, and the bench confirms the fall back to the register file. Every slot carries a distinct data pattern, so a wrong pick shows up in the operand value as well as in the select code.

// File: rtl/raw_fwd_pkg.sv
package raw_fwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF   = 2'b00,
    SRC_AGE1 = 2'b01,
    SRC_AGE2 = 2'b10
  } fwd_src_e;
endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
  parameter int REG_W = 4
) (
  input  logic [REG_W-1:0] src,
  input  logic             we,
  input  logic [REG_W-1:0] dst,
  output logic             hit
);
  always_comb hit = we && (src == dst);
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick (
  input  logic       hit1,
  input  logic       hit2,
  output logic [1:0] sel
);
  import raw_fwd_pkg::*;
  fwd_src_e pick;
  always_comb begin
    if (hit1)      pick = SRC_AGE1;
    else if (hit2) pick = SRC_AGE2;
    else           pick = SRC_RF;
    sel = pick;
  end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] rf,
  input  logic [DATA_W-1:0] v1,
  input  logic [DATA_W-1:0] v2,
  output logic [DATA_W-1:0] q
);
  import raw_fwd_pkg::*;
  always_comb begin
    unique case (sel)
      SRC_AGE1: q = v1;
      SRC_AGE2: q = v2;
      default:  q = rf;
    endcase
  end
endmodule

// File: rtl/raw_fwd_unit.sv
module raw_fwd_unit #(
  parameter int NUM_SRC = 2,
  parameter int REG_W   = 4,
  parameter int DATA_W  = 32
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0]  src_idx,
  input  logic [NUM_SRC-1:0][DATA_W-1:0] rf_data,
  input  logic                           age1_we,
  input  logic [REG_W-1:0]               age1_dst,
  input  logic [DATA_W-1:0]              age1_val,
  input  logic                           age2_we,
  input  logic [REG_W-1:0]               age2_dst,
  input  logic [DATA_W-1:0]              age2_val,
  output logic [NUM_SRC-1:0][1:0]        fwd_sel,
  output logic [NUM_SRC-1:0][DATA_W-1:0] opnd_data
);
  // one compare pair, priority pick and data mux per operand
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_op
    logic h1, h2;
    fwd_hit #(.REG_W(REG_W)) u_hit1 (
      .src(src_idx[g]), .we(age1_we), .dst(age1_dst), .hit(h1));
    fwd_hit #(.REG_W(REG_W)) u_hit2 (
      .src(src_idx[g]), .we(age2_we), .dst(age2_dst), .hit(h2));
    fwd_pick u_pick (.hit1(h1), .hit2(h2), .sel(fwd_sel[g]));
    fwd_mux #(.DATA_W(DATA_W)) u_mux (
      .sel(fwd_sel[g]), .rf(rf_data[g]), .v1(age1_val), .v2(age2_val),
      .q(opnd_data[g]));
  end
endmodule

// File: rtl/raw_fwd_chk.sv
module raw_fwd_chk #(
  parameter int NUM_SRC = 2,
  parameter int REG_W   = 4,
  parameter int DATA_W  = 32
) (
  input logic [NUM_SRC-1:0][REG_W-1:0]  src_idx,
  input logic [NUM_SRC-1:0][DATA_W-1:0] rf_data,
  input logic                           age1_we,
  input logic [REG_W-1:0]               age1_dst,
  input logic [DATA_W-1:0]              age1_val,
  input logic                           age2_we,
  input logic [REG_W-1:0]               age2_dst,
  input logic [DATA_W-1:0]              age2_val,
  input logic [NUM_SRC-1:0][1:0]        fwd_sel,
  input logic [NUM_SRC-1:0][DATA_W-1:0] opnd_data
);
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!(age1_we && age1_dst == src_idx[i]) && !(age2_we && age2_dst == src_idx[i]))
        AST_IDLE_RF: assert (fwd_sel[i] == 2'b00 && opnd_data[i] == rf_data[i]); // R1
      if (age1_we && age1_dst == src_idx[i])
        AST_AGE1_TAKES: assert (fwd_sel[i] == 2'b01 && opnd_data[i] == age1_val); // R4
      if (!(age1_we && age1_dst == src_idx[i]) && age2_we && age2_dst == src_idx[i])
        AST_AGE2_ONLY: assert (fwd_sel[i] == 2'b10 && opnd_data[i] == age2_val); // R3
      if (!age1_we)
        AST_WE1_GATES: assert (fwd_sel[i] != 2'b01); // R5
      if (!age2_we)
        AST_WE2_GATES: assert (fwd_sel[i] != 2'b10); // R5
      AST_NO_CODE3: assert (fwd_sel[i] != 2'b11); // R7
    end
  end
endmodule

bind raw_fwd_unit raw_fwd_chk #(
  .NUM_SRC(NUM_SRC), .REG_W(REG_W), .DATA_W(DATA_W)
) u_chk (
  .src_idx(src_idx), .rf_data(rf_data),
  .age1_we(age1_we), .age1_dst(age1_dst), .age1_val(age1_val),
  .age2_we(age2_we), .age2_dst(age2_dst), .age2_val(age2_val),
  .fwd_sel(fwd_sel), .opnd_data(opnd_data)
);

// File: tb/raw_fwd_unit_bench.sv
module raw_fwd_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 2;
  localparam int RW = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [NS-1:0][RW-1:0] src_idx;
  logic [NS-1:0][DW-1:0] rf_data;
  logic age1_we, age2_we;
  logic [RW-1:0] age1_dst, age2_dst;
  logic [DW-1:0] age1_val, age2_val;
  logic [NS-1:0][1:0] fwd_sel;
  logic [NS-1:0][DW-1:0] opnd_data;

  localparam logic [DW-1:0] RF0 = 32'h1111_0000;
  localparam logic [DW-1:0] RF1 = 32'h2222_0001;
  localparam logic [DW-1:0] V1  = 32'hAAAA_5555;
  localparam logic [DW-1:0] V2  = 32'hC3C3_3C3C;

  always #(CLK_PERIOD/2) clk = ~clk;

  raw_fwd_unit #(.NUM_SRC(NS), .REG_W(RW), .DATA_W(DW)) u_raw_fwd_unit (
    .src_idx(src_idx), .rf_data(rf_data),
    .age1_we(age1_we), .age1_dst(age1_dst), .age1_val(age1_val),
    .age2_we(age2_we), .age2_dst(age2_dst), .age2_val(age2_val),
    .fwd_sel(fwd_sel), .opnd_data(opnd_data));

  task automatic chk(input int op, input logic [1:0] es, input logic [DW-1:0] ed,
                     input string req);
    total++;
    if (fwd_sel[op] !== es || opnd_data[op] !== ed) begin
      bad++;
      $display("FAIL %s op%0d: sel=%b data=%h expected sel=%b data=%h",
               req, op, fwd_sel[op], opnd_data[op], es, ed);
    end
  endtask

  task automatic setup(input logic [RW-1:0] s0, input logic [RW-1:0] s1,
                       input logic w1, input logic [RW-1:0] d1,
                       input logic w2, input logic [RW-1:0] d2);
    @(negedge clk);
    src_idx[0] = s0; src_idx[1] = s1;
    age1_we = w1; age1_dst = d1; age2_we = w2; age2_dst = d2;
    #1;
  endtask

  task automatic t_reset_state();
    chk(0, 2'b00, RF0, "R1");
    chk(1, 2'b00, RF1, "R1");
  endtask

  task automatic t_no_match();
    setup(4'd3, 4'd4, 1'b1, 4'd7, 1'b1, 4'd9);
    chk(0, 2'b00, RF0, "R1");
    chk(1, 2'b00, RF1, "R1");
  endtask

  task automatic t_age1();
    setup(4'd5, 4'd6, 1'b1, 4'd5, 1'b0, 4'd0);
    chk(0, 2'b01, V1, "R2");
    chk(1, 2'b00, RF1, "R2");
  endtask

  task automatic t_age2();
    setup(4'd2, 4'd15, 1'b1, 4'd8, 1'b1, 4'd15);
    chk(1, 2'b10, V2, "R3");
    chk(0, 2'b00, RF0, "R3");
  endtask

  task automatic t_priority_and_gate();
    setup(4'd12, 4'd12, 1'b1, 4'd12, 1'b1, 4'd12);
    chk(0, 2'b01, V1, "R4");
    chk(1, 2'b01, V1, "R4");
    setup(4'd12, 4'd12, 1'b0, 4'd12, 1'b1, 4'd12);
    chk(0, 2'b10, V2, "R5");
    setup(4'd12, 4'd12, 1'b0, 4'd12, 1'b0, 4'd12);
    chk(0, 2'b00, RF0, "R5");
    chk(1, 2'b00, RF1, "R5");
  endtask

  task automatic t_independent();
    setup(4'd1, 4'd2, 1'b1, 4'd1, 1'b1, 4'd2);
    chk(0, 2'b01, V1, "R6");
    chk(1, 2'b10, V2, "R6");
    setup(4'd0, 4'd0, 1'b1, 4'd0, 1'b1, 4'd1);
    chk(0, 2'b01, V1, "R6");
  endtask

  task automatic t_same_cycle();
    // R8: change an input between edges, output must follow before the next edge
    setup(4'd9, 4'd10, 1'b0, 4'd9, 1'b0, 4'd10);
    chk(0, 2'b00, RF0, "R8");
    age1_we = 1'b1;
    #1;
    chk(0, 2'b01, V1, "R8");
    age1_val = 32'h0F0F_0F0F;
    #1;
    chk(0, 2'b01, 32'h0F0F_0F0F, "R8");
    age1_val = V1;
  endtask

  task automatic t_no_code3();
    // R7: sweep indices with both slots on; code 11 must never appear
    for (int k = 0; k < 16; k++) begin
      setup(k[RW-1:0], ~k[RW-1:0], 1'b1, 4'd6, 1'b1, 4'd9);
      total++;
      if (fwd_sel[0] === 2'b11 || fwd_sel[1] === 2'b11) begin
        bad++;
        $display("FAIL R7 idx=%0d: sel=%b/%b expected not 11", k, fwd_sel[0], fwd_sel[1]);
      end
    end
  endtask

  initial begin
    src_idx = '0;
    rf_data[0] = RF0; rf_data[1] = RF1;
    age1_we = 1'b0; age1_dst = '0; age1_val = V1;
    age2_we = 1'b0; age2_dst = '0; age2_val = V2;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    t_reset_state();
    t_no_match();
    t_age1();
    t_age2();
    t_priority_and_gate();
    t_independent();
    t_same_cycle();
    t_no_code3();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule